// File: doc/BRIEF.md
# Multi-Cycle Subtract-and-Branch Processor Core

This block is a small multi-cycle processor core that runs a single instruction: subtract one data word from another, store the difference back into memory, and branch if the difference came out negative. Each instruction word holds two signed 8-bit immediates. The upper one, called X1, is the destination and minuend address. The lower one, called X2, is both the subtrahend address and the relative branch offset. One instruction takes exactly four clock cycles. A step counter, not an opcode decoder, drives the register enables, the memory write and the two datapath selects.

The core holds a program counter, two operand registers (minuend and subtrahend), a result register and a one-stage delayed copy of the ALU's negative flag. The ALU only adds or subtracts. In the first three steps it reads the subtrahend, reads the minuend and subtracts, registering both the difference and its sign. In the last step it writes the difference back and adds either one or the sign-extended X2 to the program counter. Both memories are loaded through a load port while reset is held. Their contents can be read back through a registered peek port.

Top module: `subbr_cpu`

## Requirements
- R1: While `rst` is high (synchronous, active high), at every falling edge after the first rising edge, `pc` reads 0 and `step` reads 0, and the core writes nothing to data memory.
- R2: After `rst` falls, `step` counts 0, 1, 2, 3 on successive rising edges. It returns to 0 on the edge after the step in which the program counter is written (step 3).
- R3: An instruction word carries X1 in bits 15:8 and X2 in bits 7:0. Executing it leaves `mem[X1] = mem[X1] - mem[X2]`, modulo 2^16. The write lands on the fourth rising edge of the instruction.
- R4: If bit 15 of that difference is 0, the program counter becomes `pc + 1`.
- R5: If bit 15 of that difference is 1, the program counter becomes `pc + sext(X2)`. The flag used is the one registered at the subtraction step.
- R6: Immediates are two's-complement and sign-extended to 16 bits. An address is the extended value modulo the memory depth, so X2 = 0xFE selects cell 254 and, as an offset, branches back by 2.
- R7: When X1 equals X2, the cell becomes 0, which counts as non-negative, and the program counter becomes `pc + 1`.
- R8: The program counter changes only once every four cycles. Each instruction writes exactly one data cell, X1, and every other cell keeps its value.
- R9: While `rst` is high, `ld_we` writes `ld_data` to `ld_addr` in instruction memory if `ld_sel` is 1, or in data memory if it is 0. `pk_data` shows the word at `pk_addr` one clock later, taken from instruction memory if `pk_sel` was 1 and from data memory if it was 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; also opens the load port |
| ld_we | input | 1 | Load write strobe, honoured only during reset |
| ld_sel | input | 1 | Load target: 1 instruction memory, 0 data memory |
| ld_addr | input | 16 | Load address, taken modulo the memory depth |
| ld_data | input | 16 | Load data word |
| pk_sel | input | 1 | Peek source: 1 instruction memory, 0 data memory |
| pk_addr | input | 16 | Peek address, taken modulo the memory depth |
| pk_data | output | 16 | Registered peek data, one cycle after the address |
| pc | output | 16 | Program counter register |
| step | output | 2 | Current step of the controller |

## Verification
A wrong step count or a missing step-counter restart shows up on `step` within one cycle, and shows up on `pc` at the latest at the next instruction boundary, four cycles later. A wrong difference, sign flag or address selection first appears as a wrong `pc` at the end of the same instruction whenever it changes the branch outcome. Otherwise it stays hidden in data memory until the cell is read through the peek port. For that reason every run ends with a full comparison of data memory against a model in the bench.

// File: rtl/subbr_pkg.sv
package subbr_pkg;

  localparam int STEPS  = 4;
  localparam int STEP_W = $clog2(STEPS);

  localparam logic [STEP_W-1:0] S_GET_SUB = 2'd0;
  localparam logic [STEP_W-1:0] S_GET_MIN = 2'd1;
  localparam logic [STEP_W-1:0] S_EXEC    = 2'd2;
  localparam logic [STEP_W-1:0] S_COMMIT  = 2'd3;

  typedef struct packed {
    logic ld_sub;
    logic ld_min;
    logic ld_res;
    logic ld_pc;
    logic mem_we;
    logic adr_x2;
    logic alu_pc;
    logic alu_sub;
  } ctl_t;

endpackage

// File: rtl/subbr_ram.sv
module subbr_ram #(
  parameter int DW    = 16,
  parameter int DEPTH = 256
) (
  input  logic          clk,
  input  logic          we,
  input  logic [DW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] raddr,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] paddr,
  output logic [DW-1:0] pdata
);

  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] cells [DEPTH];

  function automatic logic [AW-1:0] idx(input logic [DW-1:0] a);
    return AW'(a % DEPTH);
  endfunction

  always_ff @(posedge clk) begin
    if (we) cells[idx(waddr)] <= wdata;
    pdata <= cells[idx(paddr)];
  end

  assign rdata = cells[idx(raddr)];

endmodule

// File: rtl/subbr_alu.sv
module subbr_alu #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  output logic [DW-1:0] y,
  output logic          neg
);

  always_comb begin
    y   = sub ? (a - b) : (a + b);
    neg = y[DW-1];
  end

endmodule

// File: rtl/subbr_ctrl.sv
module subbr_ctrl
  import subbr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              neg,
  output ctl_t              ctl,
  output logic              take,
  output logic [STEP_W-1:0] step
);

  logic [STEP_W-1:0] step_q;
  logic              neg_q;

  always_comb begin
    ctl = '0;
    case (step_q)
      S_GET_SUB: begin ctl.ld_sub = 1'b1; ctl.adr_x2 = 1'b1; end
      S_GET_MIN: ctl.ld_min = 1'b1;
      S_EXEC:    begin ctl.ld_res = 1'b1; ctl.alu_sub = 1'b1; end
      S_COMMIT:  begin ctl.ld_pc = 1'b1; ctl.mem_we = 1'b1; ctl.alu_pc = 1'b1; end
      default:   ctl = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= S_GET_SUB;
      neg_q  <= 1'b0;
    end else begin
      if (ctl.ld_pc) step_q <= S_GET_SUB;
      else           step_q <= step_q + 1'b1;
      if (ctl.ld_res) neg_q <= neg;
    end
  end

  assign step = step_q;
  assign take = neg_q;

  AST_STEP_RESTART: assert property (@(posedge clk) disable iff (rst) ctl.ld_pc |=> step_q == S_GET_SUB); // R2
  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst) !ctl.ld_pc |=> step_q == $past(step_q) + 1'b1); // R2
  AST_FLAG_HELD: assert property (@(posedge clk) disable iff (rst) (step_q != S_EXEC) |=> $stable(neg_q)); // R5

endmodule

// File: rtl/subbr_cpu.sv
module subbr_cpu
  import subbr_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_we,
  input  logic              ld_sel,
  input  logic [DW-1:0]     ld_addr,
  input  logic [DW-1:0]     ld_data,
  input  logic              pk_sel,
  input  logic [DW-1:0]     pk_addr,
  output logic [DW-1:0]     pk_data,
  output logic [DW-1:0]     pc,
  output logic [STEP_W-1:0] step
);

  localparam int XW = DW / 2;

  ctl_t          ctl;
  logic          take;
  logic          alu_neg;
  logic [DW-1:0] ir, x1_s, x2_s;
  logic [DW-1:0] p_q, a_q, t_q, r_q;
  logic [DW-1:0] mem_addr, drd, alu_a, alu_b, alu_y, pc_off;
  logic [DW-1:0] dpk, ipk;
  logic          pk_sel_q;
  logic          core_we, d_we, i_we;
  logic [DW-1:0] d_waddr, d_wdata;

  assign x1_s = {{(DW-XW){ir[DW-1]}}, ir[DW-1:XW]};
  assign x2_s = {{(DW-XW){ir[XW-1]}}, ir[XW-1:0]};

  assign mem_addr = ctl.adr_x2 ? x2_s : x1_s;
  assign pc_off   = take ? x2_s : DW'(1);
  assign alu_a    = ctl.alu_pc ? p_q : a_q;
  assign alu_b    = ctl.alu_pc ? pc_off : t_q;

  subbr_ctrl u_ctrl (
    .clk  (clk),
    .rst  (rst),
    .neg  (alu_neg),
    .ctl  (ctl),
    .take (take),
    .step (step)
  );

  subbr_alu #(.DW(DW)) u_alu (
    .a   (alu_a),
    .b   (alu_b),
    .sub (ctl.alu_sub),
    .y   (alu_y),
    .neg (alu_neg)
  );

  always_ff @(posedge clk) begin
    if (rst)            p_q <= '0;
    else if (ctl.ld_pc) p_q <= alu_y;
    if (ctl.ld_sub) t_q <= drd;
    if (ctl.ld_min) a_q <= drd;
    if (ctl.ld_res) r_q <= alu_y;
    pk_sel_q <= pk_sel;
  end

  assign core_we = ctl.mem_we && !rst;
  assign d_we    = rst ? (ld_we && !ld_sel) : core_we;
  assign d_waddr = rst ? ld_addr : mem_addr;
  assign d_wdata = rst ? ld_data : r_q;
  assign i_we    = rst && ld_we && ld_sel;

  subbr_ram #(.DW(DW), .DEPTH(DEPTH)) u_dmem (
    .clk   (clk),
    .we    (d_we),
    .waddr (d_waddr),
    .wdata (d_wdata),
    .raddr (mem_addr),
    .rdata (drd),
    .paddr (pk_addr),
    .pdata (dpk)
  );

  subbr_ram #(.DW(DW), .DEPTH(DEPTH)) u_imem (
    .clk   (clk),
    .we    (i_we),
    .waddr (ld_addr),
    .wdata (ld_data),
    .raddr (p_q),
    .rdata (ir),
    .paddr (pk_addr),
    .pdata (ipk)
  );

  assign pk_data = pk_sel_q ? ipk : dpk;
  assign pc      = p_q;

  AST_PC_QUIET: assert property (@(posedge clk) disable iff (rst) !ctl.ld_pc |=> $stable(p_q)); // R8
  AST_PC_SEQ: assert property (@(posedge clk) disable iff (rst) (ctl.ld_pc && !take) |=> p_q == $past(p_q) + DW'(1)); // R4
  AST_SIGN_MATCH: assert property (@(posedge clk) disable iff (rst) ctl.ld_res |=> take == r_q[DW-1]); // R5

endmodule

// File: tb/sim_subbr_cpu.sv
module sim_subbr_cpu;
  import subbr_pkg::*;

  localparam int DW = 16;
  localparam int DEPTH = 256;

  logic clk = 1'b0, rst = 1'b1, ld_we = 1'b0, ld_sel = 1'b0, pk_sel = 1'b0;
  logic [DW-1:0] ld_addr = '0, ld_data = '0, pk_addr = '0;
  logic [DW-1:0] pk_data, pc;
  logic [STEP_W-1:0] step;

  always #10 clk = ~clk;

  subbr_cpu #(.DW(DW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .ld_we(ld_we), .ld_sel(ld_sel), .ld_addr(ld_addr),
    .ld_data(ld_data), .pk_sel(pk_sel), .pk_addr(pk_addr), .pk_data(pk_data),
    .pc(pc), .step(step)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [15:0] mi [DEPTH];
  logic [15:0] md [DEPTH];
  logic [15:0] mpc;

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic load_all();
    rst = 1'b1;
    @(negedge clk);
    for (int i = 0; i < DEPTH; i++) begin
      ld_we = 1'b1; ld_sel = 1'b1; ld_addr = 16'(i); ld_data = mi[i];
      @(negedge clk);
    end
    for (int i = 0; i < DEPTH; i++) begin
      ld_we = 1'b1; ld_sel = 1'b0; ld_addr = 16'(i); ld_data = md[i];
      @(negedge clk);
    end
    ld_we = 1'b0;
    chk("R1", "pc in reset", pc, 16'h0000);
    chk("R1", "step in reset", {14'd0, step}, 16'h0000);
    mpc = 16'h0000;
  endtask

  task automatic run(input int n, input bit watch_steps);
    rst = 1'b0;
    for (int k = 0; k < n; k++) begin
      logic [7:0] x1, x2;
      logic [15:0] res, old_pc;
      string tag;
      old_pc = mpc;
      x1  = mi[mpc[7:0]][15:8];
      x2  = mi[mpc[7:0]][7:0];
      res = md[x1] - md[x2];
      md[x1] = res;
      if (res[15]) begin
        mpc = mpc + {{8{x2[7]}}, x2};
        tag = x2[7] ? "R6" : "R5";
      end else begin
        mpc = mpc + 16'd1;
        tag = (x1 == x2) ? "R7" : "R4";
      end
      for (int c = 1; c <= 4; c++) begin
        @(posedge clk);
        @(negedge clk);
        if (watch_steps && k == 0) begin
          chk("R2", "step sequence", {14'd0, step}, 16'(c % 4));
          if (c < 4) chk("R8", "pc held mid-instruction", pc, old_pc);
        end
      end
      chk(tag, "pc after instruction", pc, mpc);
      chk("R2", "step at boundary", {14'd0, step}, 16'h0000);
    end
  endtask

  task automatic compare_mem();
    rst = 1'b1;
    pk_sel = 1'b0;
    for (int a = 0; a < DEPTH; a++) begin
      pk_addr = 16'(a);
      @(negedge clk);
      chk("R3 R8", "data cell", pk_data, md[a]);
    end
    pk_sel = 1'b1;
    pk_addr = 16'd14;
    @(negedge clk);
    chk("R9", "instruction peek", pk_data, mi[14]);
    pk_sel = 1'b0;
  endtask

  function automatic logic [15:0] ins(input logic [7:0] a, input logic [7:0] b);
    return {a, b};
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) begin
      mi[i] = ins(8'd50, 8'd51);
      md[i] = 16'h0000;
    end
    mi[0]  = ins(8'd10, 8'd11);  md[10] = 16'd5;  md[11] = 16'd3;
    mi[1]  = ins(8'd12, 8'd13);  md[12] = 16'd3;  md[13] = 16'd7;
    mi[14] = ins(8'd20, 8'hFE);  md[20] = 16'd0;  md[254] = 16'd5;
    mi[12] = ins(8'd30, 8'd30);  md[30] = 16'd9;
    mi[13] = ins(8'd40, 8'd0);   md[0]  = 16'd1;  md[40] = 16'hFF9C;
    load_all();
    run(9, 1'b1);
    chk("R5", "halt loop reached", pc, 16'd13);
    compare_mem();

    for (int i = 0; i < DEPTH; i++) begin
      mi[i] = 16'h0000;
      md[i] = 16'h0000;
    end
    mi[0] = ins(8'd60, 8'd61); md[60] = 16'h8000; md[61] = 16'd1;
    mi[1] = ins(8'd62, 8'd63); md[62] = 16'h7FFF; md[63] = 16'hFFFF;
    load_all();
    run(4, 1'b0);
    compare_mem();

    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < DEPTH; i++) begin
        mi[i] = 16'($urandom);
        md[i] = (r == 2) ? 16'($urandom % 16) : 16'($urandom);
      end
      load_all();
      run(50, 1'b0);
      compare_mem();
    end

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule